// File: doc/BRIEF.md
# Serial-Programmed Control Register Bank with Shutdown Logic

This block is a write-only two-wire serial (I2C) slave that loads a bank of twenty 8-bit control registers. Each write transaction is a START, a device address byte with a read/write bit, a register index byte, one data byte and a STOP. The block oversamples SCL and SDA with its fast system clock. It acknowledges by asserting an open-drain pull-down enable in the ninth clock of a byte. The whole register bank is presented in parallel on one flat output vector.

A global shutdown flag is derived from four sources: a shutdown request bit in register 0, the channel current codes in registers 1 to 18 all being zero, the active-low reset pin, and an undervoltage input. The reset pin also clears every register asynchronously, and while it is held low the slave stays silent on the bus.

Top module: `led_cfg_i2c_bank`

## Requirements
- R1: SDA is sampled on SCL rising edges and each byte is assembled most significant bit first, so a stored register equals the data byte exactly as it was sent.
- R2: A first byte whose upper seven bits equal the parameter DEV_ADDR (default 7'h1C) and whose bit 0 (read/write) is 0 is acknowledged: sda_oe is 1 throughout the ninth SCL high phase of that byte.
- R3: A first byte with a different address, or with bit 0 equal to 1, is not acknowledged, and neither that byte nor anything that follows it before the next START changes any register.
- R4: An index byte below 20 is acknowledged. An index of 20 or more (up to 255) is not acknowledged, and the transaction changes no register.
- R5: After a valid index, the data byte is acknowledged and written only to the register at that index, and all other registers keep their values. The bank changes only while SCL is low.
- R6: While pin_rst_n is 0, all registers read 0 and sda_oe stays 0 whatever the bus does. After release, the registers remain 0 until they are written.
- R7: When bit 0 of register 0 is 1, shutdown_o is 1.
- R8: When bits 5:0 of every one of registers 1 to 18 are zero, shutdown_o is 1. Bits 7:6 of those registers, and all of register 19, do not count towards this condition.
- R9: shutdown_o is 1 while pin_rst_n is 0 or uvlo is 1. When none of the four conditions holds, shutdown_o is 0.
- R10: A repeated START restarts the address phase and discards a partly sent transaction without writing. A STOP before the data byte has been completely received also writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| pin_rst_n | input | 1 | Active-low reset pin: clears the bank and silences the slave |
| uvlo | input | 1 | Undervoltage indication, forces shutdown |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low (acknowledge) when 1 |
| regs_o | output | 160 | Register k occupies bits [8k+7:8k] |
| shutdown_o | output | 1 | Global shutdown flag |

## Verification
The assertions assume that SDA changes only while SCL is low, except for START and STOP edges. They also assume that every SCL low phase lasts longer than the synchronizer latency plus the two cycles the engine needs to react. Under these conditions the acknowledge enable and the register writes settle before SCL rises again. The bench keeps to this by timing every bus phase in multiples of six system clocks, changing SDA only after SCL has been low for a full phase, and moving the reset pin and uvlo on falling clock edges. Randomized transactions mix matching and foreign addresses, read bits, out-of-range indices and zero current codes, and directed sequences cover aborted and restarted transfers.

// File: rtl/led_cfg_i2c_pkg.sv
package led_cfg_i2c_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RECV,
      ST_ACK,
      ST_SKIP
   } eng_state_t;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_SUB,
      PH_DATA,
      PH_DONE
   } byte_phase_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         chain_q <= {STAGES{RESET_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
      end
   end

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
   import led_cfg_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h1C,
   parameter int         NUM_REGS = 20,
   parameter int         DATA_W   = 8,
   localparam int        IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data
);

   localparam logic [7:0] LAST_SUB = 8'(NUM_REGS - 1);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("i2c_wr_engine: serial bytes are 8 bits wide");
      end
      if (NUM_REGS > 256 || NUM_REGS < 2) begin : g_bad_depth
         $error("i2c_wr_engine: NUM_REGS must be in 2..256");
      end
   endgenerate

   eng_state_t  state_q;
   byte_phase_t phase_q;
   logic        scl_d, sda_d;
   logic [2:0]  bit_cnt_q;
   logic        got8_q;
   logic [7:0]  shift_q;
   logic [IDX_W-1:0] sub_q;

   logic scl_rise, scl_fall, start_det, stop_det;

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state_q   <= ST_IDLE;
         phase_q   <= PH_ADDR;
         bit_cnt_q <= '0;
         got8_q    <= 1'b0;
         shift_q   <= '0;
         sub_q     <= '0;
         sda_oe    <= 1'b0;
         wr_en     <= 1'b0;
         wr_idx    <= '0;
         wr_data   <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state_q   <= ST_RECV;
            phase_q   <= PH_ADDR;
            bit_cnt_q <= '0;
            got8_q    <= 1'b0;
            sda_oe    <= 1'b0;
         end else if (stop_det) begin
            state_q <= ST_IDLE;
            sda_oe  <= 1'b0;
         end else begin
            unique case (state_q)
               ST_RECV: begin
                  if (scl_rise && !got8_q) begin
                     shift_q   <= {shift_q[6:0], sda_s};
                     bit_cnt_q <= bit_cnt_q + 3'd1;
                     if (bit_cnt_q == 3'd7) got8_q <= 1'b1;
                  end else if (scl_fall && got8_q) begin
                     got8_q    <= 1'b0;
                     bit_cnt_q <= '0;
                     unique case (phase_q)
                        PH_ADDR: begin
                           if (shift_q[7:1] == DEV_ADDR && !shift_q[0]) begin
                              sda_oe  <= 1'b1;
                              state_q <= ST_ACK;
                              phase_q <= PH_SUB;
                           end else begin
                              state_q <= ST_SKIP;
                           end
                        end
                        PH_SUB: begin
                           if (shift_q <= LAST_SUB) begin
                              sub_q   <= shift_q[IDX_W-1:0];
                              sda_oe  <= 1'b1;
                              state_q <= ST_ACK;
                              phase_q <= PH_DATA;
                           end else begin
                              state_q <= ST_SKIP;
                           end
                        end
                        PH_DATA: begin
                           wr_en   <= 1'b1;
                           wr_idx  <= sub_q;
                           wr_data <= shift_q;
                           sda_oe  <= 1'b1;
                           state_q <= ST_ACK;
                           phase_q <= PH_DONE;
                        end
                        default: state_q <= ST_SKIP;
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     sda_oe  <= 1'b0;
                     state_q <= (phase_q == PH_DONE) ? ST_SKIP : ST_RECV;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file #(
   parameter int  NUM_REGS = 20,
   parameter int  DATA_W   = 8,
   localparam int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       arst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         logic [DATA_W-1:0] val_q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
               val_q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
               val_q <= wr_data;
            end
         end
         assign regs_flat[g*DATA_W +: DATA_W] = val_q;
      end
   endgenerate

endmodule

// File: rtl/shutdown_eval.sv
module shutdown_eval #(
   parameter int NUM_CH = 18,
   parameter int CODE_W = 6
) (
   input  logic                     pin_rst_n,
   input  logic                     uvlo,
   input  logic                     shdn_req,
   input  logic [NUM_CH*CODE_W-1:0] codes,
   output logic                     shutdown
);

   logic [NUM_CH-1:0] ch_live;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         assign ch_live[c] = |codes[c*CODE_W +: CODE_W];
      end
   endgenerate

   assign shutdown = ~pin_rst_n | uvlo | shdn_req | ~(|ch_live);

endmodule

// File: rtl/led_cfg_i2c_bank.sv
module led_cfg_i2c_bank #(
   parameter logic [6:0] DEV_ADDR    = 7'h1C,
   parameter int         NUM_REGS    = 20,
   parameter int         DATA_W      = 8,
   parameter int         NUM_CH      = 18,
   parameter int         CODE_W      = 6,
   parameter int         SHDN_BIT    = 0,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       pin_rst_n,
   input  logic                       uvlo,
   input  logic                       scl_i,
   input  logic                       sda_i,
   output logic                       sda_oe,
   output logic [NUM_REGS*DATA_W-1:0] regs_o,
   output logic                       shutdown_o
);

   localparam int IDX_W = $clog2(NUM_REGS);

   generate
      if (NUM_CH + 1 > NUM_REGS) begin : g_bad_ch
         $error("led_cfg_i2c_bank: channel registers exceed the bank");
      end
      if (CODE_W > DATA_W || CODE_W < 1) begin : g_bad_code
         $error("led_cfg_i2c_bank: CODE_W must be in 1..DATA_W");
      end
      if (SHDN_BIT >= DATA_W) begin : g_bad_shdn
         $error("led_cfg_i2c_bank: SHDN_BIT outside register 0");
      end
   endgenerate

   logic scl_s, sda_s;
   logic wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [DATA_W-1:0] wr_data;
   logic [NUM_CH*CODE_W-1:0] codes;

   i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
      .clk(clk), .arst_n(pin_rst_n), .din(scl_i), .dout(scl_s)
   );

   i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
      .clk(clk), .arst_n(pin_rst_n), .din(sda_i), .dout(sda_s)
   );

   i2c_wr_engine #(
      .DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
   ) u_engine (
      .clk(clk), .arst_n(pin_rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   cfg_reg_file #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .arst_n(pin_rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .regs_flat(regs_o)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_codes
         assign codes[c*CODE_W +: CODE_W] = regs_o[(c+1)*DATA_W +: CODE_W];
      end
   endgenerate

   shutdown_eval #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_shdn (
      .pin_rst_n(pin_rst_n), .uvlo(uvlo), .shdn_req(regs_o[SHDN_BIT]),
      .codes(codes), .shutdown(shutdown_o)
   );

endmodule

// File: rtl/led_cfg_i2c_bank_chk.sv
module led_cfg_i2c_bank_chk #(
   parameter int NUM_REGS = 20,
   parameter int DATA_W   = 8,
   parameter int NUM_CH   = 18,
   parameter int CODE_W   = 6
) (
   input logic                       clk,
   input logic                       pin_rst_n,
   input logic                       uvlo,
   input logic                       scl_i,
   input logic                       sda_oe,
   input logic [NUM_REGS*DATA_W-1:0] regs_o,
   input logic                       shutdown_o
);

   logic any_code;
   always_comb begin
      any_code = 1'b0;
      for (int c = 1; c <= NUM_CH; c++) begin
         if (regs_o[c*DATA_W +: CODE_W] != '0) any_code = 1'b1;
      end
   end

   always @(posedge clk) begin
      if (!pin_rst_n) begin
         assert_reset_clears_R6: assert (regs_o == '0 && !sda_oe && shutdown_o)
            else $error("reset pin low but bank not cleared or slave active");
      end
      if (uvlo) begin
         assert_uvlo_forces_R9: assert (shutdown_o)
            else $error("uvlo high without shutdown");
      end
   end

   assert_ack_scl_low_R2: assert property (@(posedge clk) disable iff (!pin_rst_n)
      !$stable(sda_oe) |-> !scl_i);

   assert_write_scl_low_R5: assert property (@(posedge clk) disable iff (!pin_rst_n)
      !$stable(regs_o) |-> !scl_i);

   assert_shdn_bit_R7: assert property (@(posedge clk) disable iff (!pin_rst_n)
      regs_o[0] |-> shutdown_o);

   assert_running_needs_code_R8: assert property (@(posedge clk) disable iff (!pin_rst_n)
      !shutdown_o |-> (any_code && !uvlo && !regs_o[0]));

endmodule

bind led_cfg_i2c_bank led_cfg_i2c_bank_chk chk_i (
   .clk(clk), .pin_rst_n(pin_rst_n), .uvlo(uvlo), .scl_i(scl_i),
   .sda_oe(sda_oe), .regs_o(regs_o), .shutdown_o(shutdown_o)
);

// File: tb/led_cfg_i2c_bank_tb_top.sv
module led_cfg_i2c_bank_tb_top;

   localparam logic [6:0] DEV = 7'h1C;
   localparam int NREG = 20;
   localparam int Q    = 6;

   logic clk = 1'b0;
   logic pin_rst_n = 1'b0;
   logic uvlo = 1'b0;
   logic scl_drv = 1'b1;
   logic sda_drv = 1'b1;
   logic sda_oe;
   logic sda_line;
   logic [NREG*8-1:0] regs_o;
   logic shutdown_o;

   int checks = 0;
   int fails  = 0;
   logic [7:0] exp_regs [NREG];

   always #5 clk = ~clk;

   assign sda_line = sda_drv & ~sda_oe;

   led_cfg_i2c_bank #(.DEV_ADDR(DEV)) dut_i (
      .clk(clk), .pin_rst_n(pin_rst_n), .uvlo(uvlo), .scl_i(scl_drv),
      .sda_i(sda_line), .sda_oe(sda_oe), .regs_o(regs_o), .shutdown_o(shutdown_o)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic exp_shutdown();
      logic live = 1'b0;
      for (int c = 1; c <= 18; c++) if (exp_regs[c][5:0] != 6'd0) live = 1'b1;
      return !pin_rst_n || uvlo || exp_regs[0][0] || !live;
   endfunction

   task automatic chk_bank(input string req);
      int bad = -1;
      for (int k = 0; k < NREG; k++)
         if (regs_o[k*8 +: 8] !== exp_regs[k] && bad < 0) bad = k;
      checks++;
      if (bad >= 0) begin
         fails++;
         $display("FAIL %s register %0d: actual=%0h expected=%0h", req, bad,
                  regs_o[bad*8 +: 8], exp_regs[bad]);
      end
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; wait_clk(Q);
      scl_drv = 1'b1; wait_clk(Q);
      sda_drv = 1'b0; wait_clk(Q);
      scl_drv = 1'b0; wait_clk(Q);
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; wait_clk(Q);
      scl_drv = 1'b1; wait_clk(Q);
      sda_drv = 1'b1; wait_clk(Q);
   endtask

   task automatic send_bit(input logic b);
      sda_drv = b;    wait_clk(Q);
      scl_drv = 1'b1; wait_clk(2*Q);
      scl_drv = 1'b0; wait_clk(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_drv = 1'b1; wait_clk(Q);
      scl_drv = 1'b1; wait_clk(Q);
      ack = sda_oe;
      wait_clk(Q);
      scl_drv = 1'b0; wait_clk(Q);
   endtask

   task automatic i2c_write(input logic [6:0] a, input logic rw, input logic [7:0] sub,
                            input logic [7:0] dat, output logic [2:0] acks);
      logic k0, k1, k2;
      bus_start();
      send_byte({a, rw}, k0);
      send_byte(sub, k1);
      send_byte(dat, k2);
      bus_stop();
      wait_clk(Q);
      acks = {k0, k1, k2};
   endtask

   task automatic model_write(input logic [6:0] a, input logic rw, input logic [7:0] sub,
                              input logic [7:0] dat, output logic [2:0] acks);
      logic m = (a == DEV) && !rw;
      logic s = m && (sub < 8'(NREG));
      acks = {m, s, s};
      if (s && pin_rst_n) exp_regs[sub[4:0]] = dat;
      if (!pin_rst_n) acks = 3'b000;
   endtask

   task automatic do_write(input string req, input logic [6:0] a, input logic rw,
                           input logic [7:0] sub, input logic [7:0] dat);
      logic [2:0] got, want;
      i2c_write(a, rw, sub, dat, got);
      model_write(a, rw, sub, dat, want);
      chk(req, 32'(got), 32'(want), "acknowledge pattern");
      chk_bank(req);
      chk(req, 32'(shutdown_o), 32'(exp_shutdown()), "shutdown flag");
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : stim
      logic ack;
      void'($urandom(32'h0C0FFEE5));
      for (int k = 0; k < NREG; k++) exp_regs[k] = 8'h00;
      wait_clk(4);
      chk_bank("R6");
      chk("R9", 32'(shutdown_o), 32'd1, "shutdown during reset pin low");
      pin_rst_n = 1'b1;
      wait_clk(4);
      chk("R8", 32'(shutdown_o), 32'd1, "all codes zero after reset");

      // R1 R2 R5: directed writes, one channel live
      do_write("R1", DEV, 1'b0, 8'd1, 8'h01);
      chk("R9", 32'(shutdown_o), 32'd0, "running with one live code");
      do_write("R5", DEV, 1'b0, 8'd19, 8'hA5);
      // R7 shutdown bit
      do_write("R7", DEV, 1'b0, 8'd0, 8'h01);
      chk("R7", 32'(shutdown_o), 32'd1, "shutdown bit set");
      do_write("R7", DEV, 1'b0, 8'd0, 8'hFE);
      chk("R7", 32'(shutdown_o), 32'd0, "shutdown bit clear, other bits set");
      // R8: upper bits only and register 19 do not count
      do_write("R8", DEV, 1'b0, 8'd1, 8'hC0);
      do_write("R8", DEV, 1'b0, 8'd19, 8'h3F);
      chk("R8", 32'(shutdown_o), 32'd1, "only upper bits and reg 19 nonzero");
      do_write("R8", DEV, 1'b0, 8'd18, 8'h20);
      chk("R8", 32'(shutdown_o), 32'd0, "last channel live");
      // R9 uvlo
      uvlo = 1'b1; wait_clk(2);
      chk("R9", 32'(shutdown_o), 32'd1, "uvlo asserted");
      uvlo = 1'b0; wait_clk(2);
      chk("R9", 32'(shutdown_o), 32'd0, "uvlo released");
      // R3 foreign address and read bit
      do_write("R3", DEV ^ 7'h01, 1'b0, 8'd2, 8'h55);
      do_write("R3", DEV, 1'b1, 8'd2, 8'h55);
      // R4 index range
      do_write("R4", DEV, 1'b0, 8'd20, 8'h77);
      do_write("R4", DEV, 1'b0, 8'd255, 8'h77);
      // R10 repeated start abandons first transfer
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd3, ack);
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      chk("R10", 32'(ack), 32'd1, "address ack after repeated start");
      send_byte(8'd4, ack);
      send_byte(8'h2A, ack);
      bus_stop(); wait_clk(Q);
      exp_regs[4] = 8'h2A;
      chk_bank("R10");
      // R10 stop in the middle of the data byte
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd6, ack);
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      bus_stop(); wait_clk(Q);
      chk_bank("R10");
      // randomized traffic
      for (int n = 0; n < 110; n++) begin
         logic [6:0] a;
         logic rw;
         logic [7:0] sub, dat;
         a   = ($urandom % 10 < 8) ? DEV : 7'($urandom);
         rw  = ($urandom % 8 == 0);
         sub = ($urandom % 6 == 0) ? 8'($urandom) : 8'($urandom % NREG);
         dat = ($urandom % 3 == 0) ? 8'($urandom & 32'hC1) : 8'($urandom);
         uvlo = ($urandom % 10 == 0);
         do_write("R5", a, rw, sub, dat);
      end
      uvlo = 1'b0;
      // R6 reset pin clears and silences
      pin_rst_n = 1'b0;
      for (int k = 0; k < NREG; k++) exp_regs[k] = 8'h00;
      wait_clk(2);
      chk_bank("R6");
      do_write("R6", DEV, 1'b0, 8'd1, 8'h3F);
      pin_rst_n = 1'b1;
      wait_clk(4);
      chk_bank("R6");
      chk("R8", 32'(shutdown_o), 32'd1, "codes zero after reset release");
      do_write("R1", DEV, 1'b0, 8'd7, 8'h96);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule